// File: doc/BRIEF.md
# Per-Stage Operation Delay Selector

This block sits beside one pipeline stage and looks at the values held in that stage's input registers. From them it works out which delay class the stage's current operation falls into. A clock generator uses that class to stretch or shorten the next clock period. The answer is given three ways:
- a one-hot class vector;
- the binary index of that class;
- a thermometer of segment enables. Each enable switches in one extra delay segment on top of the base delay that always applies.

A parameter picks the variant of the block:
- An execute-stage variant decodes the opcode and function fields of a register-format instruction.
- A decode-stage variant uses the branch-taken flag. The branch-address computation only counts toward the delay when a branch is actually taken.

The class of each operation is a parameter, so one module can serve different stage profiles. Classes are numbered from fastest (0) to slowest (NCLS-1):
- When several operations are active at once, the slowest one wins.
- Classes below a floor (the class of the shortest path that every cycle must cover anyway) are merged up into the floor class.
- Any operation the table does not know is timed in the slowest class.

Outputs are registered: they reflect the inputs sampled at the previous rising clock edge.

Top module: `opdly_sel`

## Requirements
- R1: `sel_onehot` has exactly one bit set in every cycle outside reset. It reflects the inputs sampled at the previous rising clock edge (one cycle of latency).
- R2: `sel_idx` is the binary position of the single set bit of `sel_onehot`.
- R3: In the execute variant, opcode 6'b000000 selects a register-format operation by function field. The function-field codes and their classes are:
  - 6'b100000 (add): class CLS_ADD.
  - 6'b100010 (subtract): class CLS_SUB.
  - 6'b100100 (and): class CLS_AND.
  - 6'b000000 (no-op): class CLS_NOP.
- R4: In the execute variant, a nonzero opcode, or a function code not listed in R3, gives class NCLS-1 (the slowest).
- R5: Any class below FLOOR_CLS is reported as FLOOR_CLS. With FLOOR_CLS=1, the and and no-op operations (class 0) come out as class 1.
- R6: In the decode variant, the base decode operation (class CLS_DEC_BASE) is always active. When `br_taken`=1, the branch-address operation (class CLS_BR_ADDR) is active as well, and the larger of the two classes is reported.
- R7: In the decode variant with `br_taken`=0, only CLS_DEC_BASE applies. This gives a shorter class than with the flag set, whenever CLS_BR_ADDR is the larger class.
- R8: `seg_en[k]` is 1 exactly when the reported class index is greater than k. Bit k enables delay segment k+1.
- R9: While `rst` is high at a rising edge, the outputs take these values on the next cycle:
  - `sel_onehot` has only bit NCLS-1 set;
  - `sel_idx` = NCLS-1;
  - `seg_en` is all ones.
- R10: In the decode variant, `opcode_f` and `funct_f` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_f | input | 6 | Opcode field from the stage input register |
| funct_f | input | 6 | Function field from the stage input register |
| br_taken | input | 1 | Branch-taken flag from the stage input register |
| sel_onehot | output | NCLS | Registered one-hot delay class |
| sel_idx | output | IDXW | Registered binary class index |
| seg_en | output | NCLS-1 | Registered thermometer of extra delay segment enables |

## Verification
All state in the block is in its three output registers, so any fault shows at the ports one cycle after the input that exposes it. A fault in the merge or priority logic shows up as:
- a one-hot vector with zero or two bits set;
- an index that disagrees with the one-hot bit;
- a thermometer whose count of ones differs from the index.

A fault in a class mapping shows as a class that is too fast or too slow for one specific opcode, function code or flag value. The most dangerous case is an unknown code reported faster than the slowest class, because the stage would then be clocked too fast.

// File: rtl/opdly_pkg.sv
package opdly_pkg;

  localparam int unsigned FIELD_W = 6;

  localparam logic [FIELD_W-1:0] OPC_REGFMT = 6'b000000;
  localparam logic [FIELD_W-1:0] FN_ADD     = 6'b100000;
  localparam logic [FIELD_W-1:0] FN_SUB     = 6'b100010;
  localparam logic [FIELD_W-1:0] FN_AND     = 6'b100100;
  localparam logic [FIELD_W-1:0] FN_NOP     = 6'b000000;

  typedef enum logic {
    STAGE_EXEC   = 1'b0,
    STAGE_DECODE = 1'b1
  } stage_kind_e;

  // Keep a configured class inside the legal range; out-of-range means slowest.
  function automatic int unsigned clamp_cls(input int unsigned cls, input int unsigned ncls);
    return (cls < ncls) ? cls : ncls - 1;
  endfunction

endpackage

// File: rtl/opdly_exec_map.sv
module opdly_exec_map
  import opdly_pkg::*;
#(
  parameter int unsigned NCLS    = 3,
  parameter int unsigned CLS_ADD = 1,
  parameter int unsigned CLS_SUB = 2,
  parameter int unsigned CLS_AND = 0,
  parameter int unsigned CLS_NOP = 0
) (
  input  logic [FIELD_W-1:0] opcode_f,
  input  logic [FIELD_W-1:0] funct_f,
  output logic [NCLS-1:0]    act_mask
);

  localparam int unsigned C_ADD = clamp_cls(CLS_ADD, NCLS);
  localparam int unsigned C_SUB = clamp_cls(CLS_SUB, NCLS);
  localparam int unsigned C_AND = clamp_cls(CLS_AND, NCLS);
  localparam int unsigned C_NOP = clamp_cls(CLS_NOP, NCLS);
  localparam int unsigned C_MAX = NCLS - 1;

  // One bit per active operation class; unknown codes land in the slowest class.
  always_comb begin
    act_mask = '0;
    if (opcode_f == OPC_REGFMT) begin
      case (funct_f)
        FN_ADD:  act_mask[C_ADD] = 1'b1;
        FN_SUB:  act_mask[C_SUB] = 1'b1;
        FN_AND:  act_mask[C_AND] = 1'b1;
        FN_NOP:  act_mask[C_NOP] = 1'b1;
        default: act_mask[C_MAX] = 1'b1;
      endcase
    end else begin
      act_mask[C_MAX] = 1'b1;
    end
  end

endmodule

// File: rtl/opdly_branch_map.sv
module opdly_branch_map
  import opdly_pkg::*;
#(
  parameter int unsigned NCLS         = 3,
  parameter int unsigned CLS_DEC_BASE = 1,
  parameter int unsigned CLS_BR_ADDR  = 2
) (
  input  logic            br_taken,
  output logic [NCLS-1:0] act_mask
);

  localparam int unsigned C_BASE = clamp_cls(CLS_DEC_BASE, NCLS);
  localparam int unsigned C_BR   = clamp_cls(CLS_BR_ADDR, NCLS);

  // The base decode work is always active; the address adder only matters when taken.
  always_comb begin
    act_mask         = '0;
    act_mask[C_BASE] = 1'b1;
    if (br_taken) act_mask[C_BR] = 1'b1;
  end

endmodule

// File: rtl/opdly_pick.sv
module opdly_pick
  import opdly_pkg::*;
#(
  parameter int unsigned NCLS      = 3,
  parameter int unsigned FLOOR_CLS = 0,
  localparam int unsigned IDXW     = (NCLS > 1) ? $clog2(NCLS) : 1
) (
  input  logic [NCLS-1:0] act_mask,
  output logic [NCLS-1:0] pick_oh,
  output logic [IDXW-1:0] pick_idx
);

  localparam int unsigned F = clamp_cls(FLOOR_CLS, NCLS);

  logic [NCLS-1:0] merged;
  logic            seen;

  // Fold every class at or below the floor into the floor class.
  always_comb begin
    merged = '0;
    for (int c = 0; c < NCLS; c++) begin
      if (c <= int'(F)) merged[F] = merged[F] | act_mask[c];
      else              merged[c] = act_mask[c];
    end
    if (merged == '0) merged[NCLS-1] = 1'b1;
  end

  // Keep only the slowest active class.
  always_comb begin
    seen    = 1'b0;
    pick_oh = '0;
    for (int c = NCLS - 1; c >= 0; c--) begin
      pick_oh[c] = merged[c] & ~seen;
      seen       = seen | merged[c];
    end
  end

  // Binary encode of the isolated bit.
  always_comb begin
    pick_idx = '0;
    for (int c = 0; c < NCLS; c++) begin
      if (pick_oh[c]) pick_idx = pick_idx | IDXW'(c);
    end
  end

endmodule

// File: rtl/opdly_sel.sv
module opdly_sel
  import opdly_pkg::*;
#(
  parameter stage_kind_e STAGE        = STAGE_EXEC,
  parameter int unsigned NCLS         = 3,
  parameter int unsigned FLOOR_CLS    = 0,
  parameter int unsigned CLS_ADD      = 1,
  parameter int unsigned CLS_SUB      = 2,
  parameter int unsigned CLS_AND      = 0,
  parameter int unsigned CLS_NOP      = 0,
  parameter int unsigned CLS_DEC_BASE = 1,
  parameter int unsigned CLS_BR_ADDR  = 2,
  localparam int unsigned IDXW        = (NCLS > 1) ? $clog2(NCLS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] opcode_f,
  input  logic [FIELD_W-1:0] funct_f,
  input  logic               br_taken,
  output logic [NCLS-1:0]    sel_onehot,
  output logic [IDXW-1:0]    sel_idx,
  output logic [NCLS-2:0]    seg_en
);

  localparam int unsigned FLOOR_EFF = clamp_cls(FLOOR_CLS, NCLS);
  localparam int unsigned BR_EFF    = (clamp_cls(CLS_BR_ADDR, NCLS) > FLOOR_EFF)
                                      ? clamp_cls(CLS_BR_ADDR, NCLS) : FLOOR_EFF;

  logic [NCLS-1:0] exec_mask;
  logic [NCLS-1:0] dec_mask;
  logic [NCLS-1:0] act_mask;
  logic [NCLS-1:0] pick_oh;
  logic [IDXW-1:0] pick_idx;
  logic [NCLS-2:0] thermo;

  opdly_exec_map #(
    .NCLS(NCLS), .CLS_ADD(CLS_ADD), .CLS_SUB(CLS_SUB),
    .CLS_AND(CLS_AND), .CLS_NOP(CLS_NOP)
  ) u_exec_map (
    .opcode_f(opcode_f),
    .funct_f (funct_f),
    .act_mask(exec_mask)
  );

  opdly_branch_map #(
    .NCLS(NCLS), .CLS_DEC_BASE(CLS_DEC_BASE), .CLS_BR_ADDR(CLS_BR_ADDR)
  ) u_branch_map (
    .br_taken(br_taken),
    .act_mask(dec_mask)
  );

  assign act_mask = (STAGE == STAGE_EXEC) ? exec_mask : dec_mask;

  opdly_pick #(
    .NCLS(NCLS), .FLOOR_CLS(FLOOR_CLS)
  ) u_pick (
    .act_mask(act_mask),
    .pick_oh (pick_oh),
    .pick_idx(pick_idx)
  );

  // Segment k+1 is switched in whenever the class lies above k.
  always_comb begin
    for (int k = 0; k < NCLS - 1; k++) begin
      thermo[k] = (pick_idx > IDXW'(k));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_onehot <= {1'b1, {(NCLS-1){1'b0}}};
      sel_idx    <= IDXW'(NCLS - 1);
      seg_en     <= '1;
    end else begin
      sel_onehot <= pick_oh;
      sel_idx    <= pick_idx;
      seg_en     <= thermo;
    end
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot(sel_onehot));

  p_idx_matches_bit_r2: assert property (@(posedge clk) disable iff (rst)
    sel_onehot[sel_idx] == 1'b1);

  p_floor_merge_r5: assert property (@(posedge clk) disable iff (rst)
    sel_idx >= IDXW'(FLOOR_EFF));

  p_segment_count_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(seg_en) == int'(sel_idx));

  generate
    if (STAGE == STAGE_EXEC) begin : g_exec_chk
      p_unknown_opcode_r4: assert property (@(posedge clk) disable iff (rst)
        (opcode_f != OPC_REGFMT) |=> (sel_idx == IDXW'(NCLS - 1)));
    end else begin : g_dec_chk
      p_branch_slow_r6: assert property (@(posedge clk) disable iff (rst)
        br_taken |=> (sel_idx >= IDXW'(BR_EFF)));
    end
  endgenerate

endmodule

// File: tb/opdly_sel_bench.sv
module opdly_sel_bench;
  import opdly_pkg::*;

  localparam int NCLS = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode_f = '0;
  logic [5:0] funct_f  = '0;
  logic       br_taken = 1'b0;

  logic [2:0] oh_x, oh_d;
  logic [1:0] idx_x, idx_d;
  logic [1:0] seg_x, seg_d;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  // Execute variant: add=1, sub=2, and=0, nop=0, floor=1.
  opdly_sel #(
    .STAGE(STAGE_EXEC), .NCLS(NCLS), .FLOOR_CLS(1),
    .CLS_ADD(1), .CLS_SUB(2), .CLS_AND(0), .CLS_NOP(0)
  ) u_opdly_sel (
    .clk(clk), .rst(rst), .opcode_f(opcode_f), .funct_f(funct_f),
    .br_taken(br_taken), .sel_onehot(oh_x), .sel_idx(idx_x), .seg_en(seg_x)
  );

  // Decode variant: base=1, branch address=2, floor=0.
  opdly_sel #(
    .STAGE(STAGE_DECODE), .NCLS(NCLS), .FLOOR_CLS(0),
    .CLS_DEC_BASE(1), .CLS_BR_ADDR(2)
  ) u_opdly_sel_dec (
    .clk(clk), .rst(rst), .opcode_f(opcode_f), .funct_f(funct_f),
    .br_taken(br_taken), .sel_onehot(oh_d), .sel_idx(idx_d), .seg_en(seg_d)
  );

  function automatic int exp_exec(input logic [5:0] op, input logic [5:0] fn);
    int c;
    if (op != 6'd0) c = 2;                 // R4
    else begin
      case (fn)
        6'b100000: c = 1;                  // R3 add
        6'b100010: c = 2;                  // R3 sub
        6'b100100: c = 0;                  // R3 and
        6'b000000: c = 0;                  // R3 nop
        default:   c = 2;                  // R4
      endcase
    end
    if (c < 1) c = 1;                      // R5 floor
    return c;
  endfunction

  function automatic int exp_dec(input logic br);
    return br ? 2 : 1;                     // R6 / R7
  endfunction

  task automatic check_out(input string tag, input logic [2:0] oh,
                           input logic [1:0] idx, input logic [1:0] seg, input int e);
    logic [2:0] eoh;
    logic [1:0] eseg;
    eoh  = 3'(1 << e);
    eseg = 2'((1 << e) - 1);
    checks++;
    if (oh !== eoh || idx !== 2'(e) || seg !== eseg) begin
      failures++;
      $display("FAIL %s: got oh=%b idx=%0d seg=%b, expected oh=%b idx=%0d seg=%b",
               tag, oh, idx, seg, eoh, e, eseg);
    end
  endtask

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic br,
                       input string tx, input string td);
    @(negedge clk);
    opcode_f = op; funct_f = fn; br_taken = br;
    @(negedge clk);
    check_out(tx, oh_x, idx_x, seg_x, exp_exec(op, fn));
    check_out(td, oh_d, idx_d, seg_d, exp_dec(br));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired: got timeout, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check_out("R9 reset exec", oh_x, idx_x, seg_x, 2);
    check_out("R9 reset dec", oh_d, idx_d, seg_d, 2);
    rst = 1'b0;

    apply(6'd0, 6'b100000, 1'b0, "R3 add",             "R7 flag clear");
    apply(6'd0, 6'b100010, 1'b1, "R3 sub",             "R6 flag set");
    apply(6'd0, 6'b100100, 1'b0, "R5 and merged",      "R7 flag clear");
    apply(6'd0, 6'b000000, 1'b1, "R5 nop merged",      "R6 flag set");
    apply(6'd0, 6'b100001, 1'b0, "R4 unknown funct",   "R10 fields ignored");
    apply(6'h23, 6'b100000, 1'b0, "R4 unknown opcode", "R10 fields ignored");
    apply(6'h3f, 6'b100100, 1'b1, "R4 unknown opcode", "R10 fields ignored");
    apply(6'd0, 6'b100000, 1'b0, "R1 back to add",     "R10 fields ignored");

    for (int i = 0; i < 500; i++) begin
      logic [5:0] op, fn;
      int sel;
      op  = ($urandom % 4 == 0) ? 6'($urandom) : 6'd0;
      sel = int'($urandom % 6);
      case (sel)
        0: fn = 6'b100000;
        1: fn = 6'b100010;
        2: fn = 6'b100100;
        3: fn = 6'b000000;
        default: fn = 6'($urandom);
      endcase
      apply(op, fn, 1'($urandom), "R1 R2 R8 random exec", "R10 random dec");
    end

    @(negedge clk);
    rst = 1'b1;
    opcode_f = 6'd0; funct_f = 6'b100100; br_taken = 1'b0;
    @(negedge clk);
    check_out("R9 mid reset exec", oh_x, idx_x, seg_x, 2);
    check_out("R9 mid reset dec", oh_d, idx_d, seg_d, 2);
    rst = 1'b0;
    @(negedge clk);
    check_out("R1 after reset exec", oh_x, idx_x, seg_x, 1);
    check_out("R7 after reset dec", oh_d, idx_d, seg_d, 1);

    finish_run();
  end

endmodule